// File: doc/BRIEF.md
# Programmable Wait-State Handshake Generator

This block drives the single ready handshake line that a processor watches while a DRAM access is in progress. It decides, from a small programming word, how long the processor is held off before the first data is ready, and how it is held off again between the beats of a burst. The line can follow either of two conventions. In the wait convention the line is low while the processor must wait. In the acknowledge convention the line is low once data is ready.

The access timing is measured from the access row strobe. The burst timing is measured from the column enable inputs. Both clock edges are used, so a programmed delay can end on the falling edge, half a clock period earlier than the next rising edge. Generating the row and column strobes themselves is left to neighbouring logic.

Top module: `hs_wait_gen`

## Requirements
- R1: `cfg_word` bit 4 selects the convention: 0 gives the wait convention (`hs_n` high = ready, low = wait), 1 gives the acknowledge convention (`hs_n` low = ready, high = not ready). Bits 3:2 hold the first-access delay code and bits 1:0 the burst code.
- R2: During reset, and in any cycle with `acc_req` low, `hs_n` shows the not-ready level of the selected convention.
- R3: Delay code 00: in the acknowledge convention, ready appears in the same cycle `ras_act` is high. In the wait convention, a non-delayed access (`acc_delayed` low) is ready at once, and a delayed access is ready while `ras_act` is high.
- R4: Delay code 01: in the acknowledge convention, ready appears at the first rising edge that samples `ras_act` high. In the wait convention, it appears at the first falling edge that samples it high.
- R5: Delay code 10: in the acknowledge convention, ready appears at the first falling edge that samples `ras_act` high. In the wait convention, a non-delayed access is ready at once and a delayed one follows the acknowledge rule.
- R6: Delay code 11: in the wait convention, ready appears at the first rising edge that samples `ras_act` high. In the acknowledge convention, it appears at the falling edge after that rising edge, 1.5 cycles later.
- R7: The first-access phase ends at the first rising edge where ready is shown with `acc_req` high. The burst phase then lasts until `acc_req` drops. A fresh request starts again in the first-access phase.
- R8: Burst code 00: the line stays ready for the whole burst phase, whatever `cas_en` does.
- R9: Burst code 01: the line becomes not ready as soon as no bit of `cas_en` is set. It returns to ready at the first rising edge that samples a bit set.
- R10: Burst code 10: like R9, except that the line returns to ready at the first falling edge that samples a bit of `cas_en` set.
- R11: Burst code 11: in the burst phase, ready follows directly whether any bit of `cas_en` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| acc_req | input | 1 | Access request, active high |
| ras_act | input | 1 | Access row strobe is asserted, active high |
| acc_delayed | input | 1 | The current access was delayed, active high |
| cas_en | input | CAS_W | Column enables, active high; any set bit counts as enabled |
| cfg_word | input | 5 | Programming word: convention, delay code, burst code |
| hs_n | output | 1 | Handshake line, active low |

## Verification
The assertions check, on every cycle, the following behaviours:
- the idle not-ready level;
- the acknowledge release one rising edge after the row strobe under code 01;
- the forced not-ready level of burst code 01 after a sampled column gap;
- the constant ready level of burst code 00;
- the clearing of the burst phase when the request drops.

The half-cycle releases on the falling edge, and the choice between immediate and strobe-gated ready for delayed and non-delayed wait accesses, only appear in the bench's scenarios. The same holds for the recovery from column gaps and for the hand-over from first-access to burst timing. The bench checks these twice per cycle, before and after the falling edge, across all 32 programming words.

// File: rtl/hs_pkg.sv
package hs_pkg;
  // Programming word fields (bit 4 convention, 3:2 delay, 1:0 burst).
  typedef struct packed {
    logic       ack_mode;
    logic [1:0] dly;
    logic [1:0] bst;
  } hs_cfg_t;

  localparam logic [1:0] CODE_0 = 2'b00;
  localparam logic [1:0] CODE_1 = 2'b01;
  localparam logic [1:0] CODE_2 = 2'b10;
  localparam logic [1:0] CODE_3 = 2'b11;
endpackage

// File: rtl/hs_edge_sampler.sv
module hs_edge_sampler #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_rise,
  output logic [W-1:0] q_fall,
  output logic [W-1:0] q_rise_fall
);
  // Rising-edge sample of d.
  always_ff @(posedge clk) begin
    if (rst) q_rise <= '0;
    else     q_rise <= d;
  end

  // Falling-edge samples: d itself and the rising-edge copy.
  always_ff @(negedge clk) begin
    if (rst) begin
      q_fall      <= '0;
      q_rise_fall <= '0;
    end else begin
      q_fall      <= d;
      q_rise_fall <= q_rise;
    end
  end
endmodule

// File: rtl/hs_first_gate.sv
module hs_first_gate
  import hs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  hs_cfg_t cfg,
  input  logic    ras,
  input  logic    ras_r,
  input  logic    ras_f,
  input  logic    ras_rf,
  input  logic    delayed,
  output logic    first_rdy
);
  always_comb begin
    if (cfg.ack_mode) begin
      unique case (cfg.dly)
        CODE_0:  first_rdy = ras;
        CODE_1:  first_rdy = ras_r;
        CODE_2:  first_rdy = ras_f;
        default: first_rdy = ras_rf;
      endcase
    end else begin
      unique case (cfg.dly)
        CODE_0:  first_rdy = !delayed || ras;
        CODE_1:  first_rdy = ras_f;
        CODE_2:  first_rdy = !delayed || ras_f;
        default: first_rdy = ras_r;
      endcase
    end
  end

  // R4: acknowledge, code 01 -> ready once a rising edge has seen the strobe.
  a_r4_ack_rise: assert property (@(posedge clk) disable iff (rst)
    (cfg.ack_mode && cfg.dly == CODE_1 && $past(ras) && $stable(cfg)) |-> first_rdy);
endmodule

// File: rtl/hs_burst_gate.sv
module hs_burst_gate
  import hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] bst,
  input  logic       cas_any,
  input  logic       cas_r,
  input  logic       cas_f,
  output logic       burst_rdy
);
  always_comb begin
    unique case (bst)
      CODE_0:  burst_rdy = 1'b1;
      CODE_1:  burst_rdy = cas_any && cas_r;
      CODE_2:  burst_rdy = cas_any && cas_f;
      default: burst_rdy = cas_any;
    endcase
  end

  // R9: a gap seen by the last rising edge keeps the beat not ready.
  a_r9_gap_holds: assert property (@(posedge clk) disable iff (rst)
    (bst == CODE_1 && $stable(bst) && !$past(cas_any)) |-> !burst_rdy);
endmodule

// File: rtl/hs_wait_gen.sv
module hs_wait_gen
  import hs_pkg::*;
#(
  parameter int CAS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_req,
  input  logic             ras_act,
  input  logic             acc_delayed,
  input  logic [CAS_W-1:0] cas_en,
  input  logic [4:0]       cfg_word,
  output logic             hs_n
);
  localparam int SMP_W = 2; // row strobe + column-enable summary

  hs_cfg_t          cfg;
  logic             cas_any;
  logic [SMP_W-1:0] smp_d, smp_r, smp_f, smp_rf;
  logic             first_rdy, burst_rdy, ready, in_burst;

  assign cfg     = hs_cfg_t'(cfg_word);
  assign cas_any = |cas_en;
  assign smp_d   = {cas_any, ras_act};

  hs_edge_sampler #(.W(SMP_W)) u_smp (
    .clk(clk), .rst(rst), .d(smp_d),
    .q_rise(smp_r), .q_fall(smp_f), .q_rise_fall(smp_rf)
  );

  hs_first_gate u_first (
    .clk(clk), .rst(rst), .cfg(cfg), .ras(ras_act),
    .ras_r(smp_r[0]), .ras_f(smp_f[0]), .ras_rf(smp_rf[0]),
    .delayed(acc_delayed), .first_rdy(first_rdy)
  );

  hs_burst_gate u_burst (
    .clk(clk), .rst(rst), .bst(cfg.bst), .cas_any(cas_any),
    .cas_r(smp_r[1]), .cas_f(smp_f[1]), .burst_rdy(burst_rdy)
  );

  // Phase register: first-access timing until ready is reached, then burst timing.
  always_ff @(posedge clk) begin
    if (rst) in_burst <= 1'b0;
    else     in_burst <= acc_req && (in_burst || first_rdy);
  end

  assign ready = acc_req && (in_burst ? burst_rdy : first_rdy);
  assign hs_n  = cfg.ack_mode ? !ready : ready;

  // R2: idle request shows the not-ready level.
  a_r2_idle_level: assert property (@(posedge clk) disable iff (rst)
    !acc_req |-> (hs_n == cfg_word[4]));
  // R7: dropping the request ends the burst phase.
  a_r7_phase_clear: assert property (@(posedge clk) disable iff (rst)
    !acc_req |=> !in_burst);
  // R8: burst code 00 never withdraws ready.
  a_r8_burst_free: assert property (@(posedge clk) disable iff (rst)
    (acc_req && in_burst && cfg_word[1:0] == 2'b00) |-> (hs_n != cfg_word[4]));
endmodule

// File: tb/hs_wait_gen_tb.sv
module hs_wait_gen_tb;
  localparam int CAS_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             acc_req = 1'b0, ras_act = 1'b0, acc_delayed = 1'b0;
  logic [CAS_W-1:0] cas_en = '0;
  logic [4:0]       cfg_word = 5'b10000;
  logic             hs_n;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;
  // bench reference state
  bit m_rq, m_rh, m_rqh, m_cq, m_ch, m_burst;

  always #4 clk = ~clk;

  hs_wait_gen #(.CAS_W(CAS_W)) u_dut (
    .clk(clk), .rst(rst), .acc_req(acc_req), .ras_act(ras_act),
    .acc_delayed(acc_delayed), .cas_en(cas_en), .cfg_word(cfg_word), .hs_n(hs_n)
  );

  function automatic bit first_ok(input logic [4:0] w, input bit ras, input bit dl);
    case ({w[4], w[3:2]})
      3'b100: return ras;          // R3
      3'b101: return m_rq;         // R4
      3'b110: return m_rh;         // R5
      3'b111: return m_rqh;        // R6
      3'b000: return !dl || ras;   // R3
      3'b001: return m_rh;         // R4
      3'b010: return !dl || m_rh;  // R5
      default: return m_rq;        // R6
    endcase
  endfunction

  function automatic bit burst_ok(input logic [1:0] b, input bit ca);
    case (b)
      2'b00: return 1'b1;          // R8
      2'b01: return ca && m_cq;    // R9
      2'b10: return ca && m_ch;    // R10
      default: return ca;          // R11
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] w, input bit rq);
    if (!rq) return "R2";
    if (m_burst) begin
      case (w[1:0])
        2'b00: return "R8 R7";
        2'b01: return "R9 R7";
        2'b10: return "R10 R7";
        default: return "R11 R7";
      endcase
    end
    case (w[3:2])
      2'b00: return "R3 R1";
      2'b01: return "R4 R1";
      2'b10: return "R5 R1";
      default: return "R6 R1";
    endcase
  endfunction

  function automatic bit exp_ready();
    if (!acc_req) return 1'b0;
    if (m_burst) return burst_ok(cfg_word[1:0], |cas_en);
    return first_ok(cfg_word, ras_act, acc_delayed);
  endfunction

  task automatic check_now(input string when);
    bit r = exp_ready();
    logic e = cfg_word[4] ? !r : r;
    n_run++;
    if (hs_n !== e) begin
      n_fail++;
      $display("FAIL %s cfg=%b (%s): hs_n=%b expected %b at %0t",
               tag_of(cfg_word, acc_req), cfg_word, when, hs_n, e, $time);
    end
  endtask

  task automatic cyc(input bit rq, input bit ras, input bit dl, input logic [CAS_W-1:0] ce);
    bit rl;
    @(posedge clk);
    #1;
    acc_req = rq; ras_act = ras; acc_delayed = dl; cas_en = ce;
    #1;
    check_now("high phase");
    @(negedge clk);
    m_rqh = m_rq; m_rh = ras; m_ch = |ce;
    #2;
    check_now("low phase");
    rl = m_burst ? 1'b0 : first_ok(cfg_word, ras, dl);
    m_burst = rq && (m_burst || rl);
    m_rq = ras; m_cq = |ce;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    n_run++;
    if (hs_n !== 1'b1) begin
      n_fail++;
      $display("FAIL R2 reset: hs_n=%b expected 1", hs_n);
    end
    @(posedge clk); #1; rst = 1'b0;
    // model regs are zero, matching the reset state
    for (int w = 0; w < 32; w++) begin
      cfg_word = 5'(w);
      for (int t = 0; t < 3; t++) begin
        bit dl = $urandom_range(0, 1) == 1;
        int pre = $urandom_range(1, 2);
        cyc(0, 0, dl, '0);
        cyc(0, 0, dl, '1);
        for (int i = 0; i < pre; i++) cyc(1, 0, dl, '1);
        for (int i = 0; i < 9; i++) begin
          logic [CAS_W-1:0] ce;
          if (t == 0) ce = (i % 3 == 2) ? '0 : 4'b0011;  // directed column gaps
          else ce = ($urandom_range(0, 2) == 0) ? '0 : CAS_W'($urandom);
          cyc(1, 1, dl, ce);
        end
        cyc(0, 0, dl, '1);
      end
    end
    // directed: request dropped mid-burst, then a fresh access (R7)
    cfg_word = 5'b11101;
    cyc(1, 1, 0, '1); cyc(1, 1, 0, '1); cyc(1, 1, 0, '1);
    cyc(0, 1, 0, '1); cyc(1, 0, 0, '1); cyc(1, 1, 0, '1); cyc(1, 1, 0, '1);
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1600000;
    if (!done_flag) begin
      done_flag = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not end");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule